// File: doc/BRIEF.md
# DDR Read Strobe Sequencer

This block produces the device-side read strobe and data-drive controls for DDR SDRAM read bursts. It runs on a clock at twice the memory clock rate, so one internal cycle is one half memory clock (a tick). A read request is accepted only on the tick that lines up with the rising memory clock. The block then plays out a fixed timeline. It drives the strobe low two ticks ahead of data as a preamble. It sends four data beats, one per tick, with the strobe changing on every beat. After the last beat it holds the strobe low for one tick as a postamble, then releases it to high impedance.

Data words come from a simple source. The block raises a pop request one tick before each beat and puts the word it captured on the data output during that beat. A request whose first beat lands directly after the last beat of the burst in flight is merged: the strobe stays driven and keeps toggling with no preamble or postamble between the bursts. A request whose beats would collide with beats already scheduled is dropped and flagged. The burst in flight is not affected.

High impedance is represented by deasserted output enables. The pad tri-state buffers sit outside this block.

Top module: `rd_strobe_seq`

## Requirements
- R1: During reset and right after it, `dqs_oe_o`, `dq_oe_o`, `src_pop_o` and `rd_err_o` are 0, and `dqs_o` and `dq_o` are 0.
- R2: A request accepted at clock edge c gives `dq_oe_o` = 1 in exactly the four internal cycles that follow edges c+5 through c+8 (read latency of 2.5 memory clocks).
- R3: When no beat occupies the two ticks before a burst's first beat, `dqs_oe_o` = 1 and `dqs_o` = 0 in those two ticks (preamble).
- R4: After the last beat of a run, `dqs_oe_o` = 1 and `dqs_o` = 0 for one tick. `dqs_oe_o` then returns to 0 unless a preamble or beat of a later burst occupies that tick.
- R5: On the first beat of a contiguous run of beats `dqs_o` = 0, and it inverts on every following beat of the run.
- R6: A request accepted four ticks after the previous accepted request merges gaplessly: beats continue on consecutive ticks, `dqs_oe_o` stays 1 and the strobe keeps alternating across the burst boundary.
- R7: A request whose beats would coincide with an already scheduled beat is rejected. `rd_err_o` = 1 for the one cycle after its edge, and the outputs follow the earlier schedule unchanged.
- R8: `mclk_rise_o` is 1 in the first cycle after reset and alternates every cycle. `rd_i` is only sampled at an edge where `mclk_rise_o` is 1, and otherwise has no effect on any output.
- R9: `src_pop_o` = 1 in the cycle right before each beat. The word on `src_data_i` at that edge appears on `dq_o` during the beat.
- R10: `dq_oe_o` is 1 only on beat ticks, while `dqs_oe_o` is 1 exactly on preamble, beat and postamble ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock at twice the memory clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read request, sampled at rising-phase edges |
| mclk_rise_o | output | 1 | High when the next edge is a rising-phase edge |
| src_data_i | input | DATA_W | Data word from the source |
| src_pop_o | output | 1 | Source advance request, one cycle ahead of each beat |
| dqs_o | output | 1 | Strobe value |
| dqs_oe_o | output | 1 | Strobe drive enable (0 = high impedance) |
| dq_o | output | DATA_W | Read data |
| dq_oe_o | output | 1 | Data drive enable (0 = high impedance) |
| rd_err_o | output | 1 | Pulse for a rejected overlapping request |

## Verification
The assertions check on every cycle the local shape of the strobe:
- it starts low on a run's first beat and flips on every later beat;
- every rise of the strobe enable begins with a low non-beat tick;
- every fall of the data enable is followed by a driven-low postamble;
- runs of beats are multiples of the burst length;
- a pop is always followed by a beat;
- off-phase requests never raise an error.

Only the bench's scenarios can show the absolute timing. That covers the exact latency from a request to its beats and the preamble width. It also covers the gapless merge at a four-tick spacing against the split timelines at six and eight ticks, rejection at two ticks with the earlier burst intact, and the ordering of data words from the source.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_LOW  = 2'd1,
    SLOT_BEAT = 2'd2
  } slot_e;
endpackage

// File: rtl/rsq_phase.sv
module rsq_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rise_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign rise_o = ~phase_q;
endmodule

// File: rtl/rsq_sched.sv
module rsq_sched
  import rsq_pkg::*;
#(
  parameter int unsigned RL_TICKS   = 5,
  parameter int unsigned BURST_LEN  = 4,
  parameter int unsigned PRE_TICKS  = 2,
  parameter int unsigned POST_TICKS = 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  take_i,
  output slot_e slot_o,
  output logic  next_beat_o,
  output logic  err_o
);
  localparam int unsigned DEPTH = RL_TICKS + BURST_LEN + POST_TICKS;

  function automatic logic [DEPTH-1:0] span(int unsigned lo, int unsigned n);
    logic [DEPTH-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < DEPTH; i++)
      if (i >= lo && i < lo + n) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [DEPTH-1:0] BEAT_MASK = span(RL_TICKS, BURST_LEN);
  localparam logic [DEPTH-1:0] LOW_MASK  = span(RL_TICKS - PRE_TICKS, PRE_TICKS)
                                         | span(RL_TICKS + BURST_LEN, POST_TICKS);

  // bit i of the timeline = tick i cycles after the current one
  logic [DEPTH-1:0] beat_q, low_q, beat_sh, low_sh;
  logic             clash, accept, err_q;

  assign beat_sh = beat_q >> 1;
  assign low_sh  = low_q >> 1;
  assign clash   = |(beat_sh & BEAT_MASK);
  assign accept  = take_i & ~clash;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      low_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      beat_q <= beat_sh | (accept ? BEAT_MASK : '0);
      low_q  <= low_sh  | (accept ? LOW_MASK  : '0);
      err_q  <= take_i & clash;
    end
  end

  always_comb begin
    if (beat_q[0])     slot_o = SLOT_BEAT;
    else if (low_q[0]) slot_o = SLOT_LOW;
    else               slot_o = SLOT_IDLE;
  end

  assign next_beat_o = beat_q[1];
  assign err_o       = err_q;

  // R7
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
endmodule

// File: rtl/rsq_out.sv
module rsq_out
  import rsq_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  slot_e             slot_i,
  input  logic              next_beat_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_pop_o,
  output logic              dqs_o,
  output logic              dqs_oe_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic              strb_q;
  logic [DATA_W-1:0] dq_q;
  logic              cur_beat;

  assign cur_beat = (slot_i == SLOT_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q <= 1'b0;
      dq_q   <= '0;
    end else begin
      // first beat of a run starts low, later beats alternate
      strb_q <= next_beat_i & cur_beat & ~strb_q;
      if (next_beat_i) dq_q <= src_data_i;
    end
  end

  assign src_pop_o = next_beat_i;
  assign dq_oe_o   = cur_beat;
  assign dqs_oe_o  = (slot_i != SLOT_IDLE);
  assign dqs_o     = cur_beat & strb_q;
  assign dq_o      = dq_q;

  logic [7:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (dq_oe_o) run_q <= run_q + 8'd1;
    else              run_q <= '0;
  end

  // R5
  first_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> !dqs_o);
  // R5
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && $past(dq_oe_o)) |-> (dqs_o != $past(dqs_o)));
  // R2
  run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> (int'(run_q) % BURST_LEN == 0));
  // R9
  pop_then_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_pop_o |=> dq_oe_o);
endmodule

// File: rtl/rd_strobe_seq.sv
module rd_strobe_seq
  import rsq_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned RL_TICKS   = 5,
  parameter int unsigned BURST_LEN  = 4,
  parameter int unsigned PRE_TICKS  = 2,
  parameter int unsigned POST_TICKS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  output logic              mclk_rise_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_pop_o,
  output logic              dqs_o,
  output logic              dqs_oe_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              rd_err_o
);
  slot_e slot;
  logic  next_beat;
  logic  rise;

  rsq_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_o (rise)
  );

  rsq_sched #(
    .RL_TICKS   (RL_TICKS),
    .BURST_LEN  (BURST_LEN),
    .PRE_TICKS  (PRE_TICKS),
    .POST_TICKS (POST_TICKS)
  ) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (rd_i & rise),
    .slot_o      (slot),
    .next_beat_o (next_beat),
    .err_o       (rd_err_o)
  );

  rsq_out #(
    .DATA_W    (DATA_W),
    .BURST_LEN (BURST_LEN)
  ) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_i      (slot),
    .next_beat_i (next_beat),
    .src_data_i  (src_data_i),
    .src_pop_o   (src_pop_o),
    .dqs_o       (dqs_o),
    .dqs_oe_o    (dqs_oe_o),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o)
  );

  assign mclk_rise_o = rise;

  // R3
  preamble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dqs_oe_o) |-> (!dq_oe_o && !dqs_o));
  // R4
  postamble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> (dqs_oe_o && !dqs_o));
  // R8
  off_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !mclk_rise_o) |=> !rd_err_o);
  // R10
  data_in_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> dqs_oe_o);
endmodule

// File: tb/rd_strobe_seq_bench.sv
module rd_strobe_seq_bench;
  localparam int DW   = 16;
  localparam int LAST = 3000;
  localparam int N    = 3100;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd;
  logic          rise;
  logic [DW-1:0] src_data;
  logic          pop;
  logic          dqs, dqs_oe, dq_oe, err;
  logic [DW-1:0] dq;

  int total = 0;
  int bad   = 0;

  bit cmd_at [0:N-1];
  bit ex_beat[0:N-1];
  bit ex_low [0:N-1];
  bit ex_err [0:N-1];
  int pop_cnt;
  int beat_no;
  bit prev_strb;

  always #10 clk = ~clk;

  rd_strobe_seq u_rd_strobe_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rd_i        (rd),
    .mclk_rise_o (rise),
    .src_data_i  (src_data),
    .src_pop_o   (pop),
    .dqs_o       (dqs),
    .dqs_oe_o    (dqs_oe),
    .dq_o        (dq),
    .dq_oe_o     (dq_oe),
    .rd_err_o    (err)
  );

  function automatic logic [DW-1:0] word(int n);
    return DW'(n * 40503 + 4660);
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n)   pop_cnt <= 0;
    else if (pop) pop_cnt <= pop_cnt + 1;
  assign src_data = word(pop_cnt);

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // model of a request sampled at edge c
  task automatic model(int c);
    bit hit = 0;
    for (int k = 5; k <= 8; k++) if (ex_beat[c+k]) hit = 1;
    if (hit) ex_err[c] = 1;
    else begin
      for (int k = 5; k <= 8; k++) ex_beat[c+k] = 1;
      ex_low[c+3] = 1; ex_low[c+4] = 1; ex_low[c+9] = 1;
    end
  endtask

  task automatic drive(int c);
    rd = cmd_at[c];
    // R8 rising phase on odd edges counted from reset release
    chk(rise == (c % 2 == 1), "R8", rise, (c % 2 == 1));
    if (cmd_at[c] && (c % 2 == 1)) model(c);
  endtask

  task automatic check(int c);
    bit  eb  = ex_beat[c];
    bit  el  = ex_low[c] && !eb;
    bit  es;
    string lr;
    chk(dq_oe == eb, "R2", dq_oe, eb);
    lr = eb ? "R10" : (ex_beat[c+1] || ex_beat[c+2]) ? "R3" : "R4";
    chk(dqs_oe == (eb || el), lr, dqs_oe, (eb || el));
    if (eb) begin
      es = ex_beat[c-1] ? ~prev_strb : 1'b0;
      prev_strb = es;
      chk(dqs == es, "R5", dqs, es);
      chk(dq == word(beat_no), "R9", dq, word(beat_no));
      beat_no++;
    end else begin
      chk(dqs == 1'b0, el ? "R3" : "R10", dqs, 0);
    end
    chk(pop == ex_beat[c+1], "R9", pop, ex_beat[c+1]);
    chk(err == ex_err[c], "R7", err, ex_err[c]);
  endtask

  initial begin
    // watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1357);
    // directed: single, gapless (+4), +6, +8, reject (+2), triple gapless, off-phase
    cmd_at[11] = 1;
    cmd_at[31] = 1; cmd_at[35] = 1;
    cmd_at[61] = 1; cmd_at[67] = 1;
    cmd_at[91] = 1; cmd_at[99] = 1;
    cmd_at[121] = 1; cmd_at[123] = 1;
    cmd_at[151] = 1; cmd_at[155] = 1; cmd_at[159] = 1;
    cmd_at[180] = 1;
    for (int c = 200; c < LAST - 20; c++)
      cmd_at[c] = (c % 2 == 1) ? ($urandom % 100 < 35) : ($urandom % 100 < 30);

    rd = 1'b0; rst_n = 1'b0; prev_strb = 0; beat_no = 0;
    repeat (3) @(negedge clk);
    // R1 outputs idle in reset
    chk({dqs_oe, dq_oe, pop, err, dqs} == 5'b0, "R1", {dqs_oe, dq_oe, pop, err, dqs}, 0);
    chk(dq == '0, "R1", dq, 0);
    rst_n = 1'b1;
    drive(1);
    for (int c = 1; c <= LAST; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == 1) chk({dqs_oe, dq_oe, err} == 3'b0, "R1", {dqs_oe, dq_oe, err}, 0);
      if (c == 40) begin
        // R6 second burst's first beat follows the first burst's high beat
        chk(dq_oe && dqs_oe && !dqs, "R6", {dq_oe, dqs_oe, dqs}, 3'b110);
      end
      if (c >= 183 && c <= 192)
        chk(!dqs_oe, "R8", dqs_oe, 0);
      check(c);
      drive(c + 1);
    end
    rd = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule